// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shifter

This block is a shift engine for serial EEPROMs with a clock pin and one bidirectional data pin. Firmware loads a data byte, then issues a command that names the direction, the number of clock pulses and how the data pin behaves at the end. On a write, the engine clocks out the top bits of the data register. On a read, it clocks bits in and leaves them right-justified in that register. Firmware keeps control of chip select and of the order of EEPROM opcodes, addresses and data.

The serial clock is the system clock divided by a fixed amount, with equal high and low times. A command may also release the data pin and then wait for the device to pull it high as a ready signal. A programmable limit ends that wait. The block reports a busy flag, a sticky error flag and a single-cycle done pulse.

Top module: `uwire_shifter`

## Requirements
- R1: An accepted command with clamped count N>0 raises busy at the accepting clock edge and keeps it high for exactly 2*N*HALF_DIV cycles. During that time sclk gives N pulses, each HALF_DIV cycles high and HALF_DIV cycles low. Outside busy, sclk is low.
- R2: A count above the register width (8 by default) is treated as the full width.
- R3: A command with count 0 never raises busy, gives no sclk pulse and no done_irq pulse. It clears err.
- R4: A write drives sd_oe high while busy and sends data bits from bit 7 downward, the top N bits in order. sd_out changes only while sclk is low and stays constant while sclk is high.
- R5: A read keeps sd_oe low and samples sd_in on each sclk rising edge. Afterwards, data_out bits N-1..0 hold the samples in arrival order, with the first sample in bit N-1, and the upper bits are zero.
- R6: After a write, data_out equals the loaded byte shifted left by N, with zeros shifted in. sd_oe stays high after the last bit unless cmd_release or cmd_wait was set; in that case it goes low.
- R7: done_irq is a one-cycle pulse in the first cycle after a busy command ends.
- R8: cmd_valid while busy is ignored and does not change the running command. It sets err, which stays set until the next accepted command.
- R9: With cmd_wait set, after the last bit the data pin is released and busy holds until sd_in is sampled high. The command then ends with err low.
- R10: If sd_in stays low during the wait, busy falls tmo_limit+1 cycles after the last bit, err is set and done_irq still pulses.
- R11: data_wr loads data_in into the data register only while idle. While busy it is ignored.
- R12: After reset, busy, sclk, sd_oe, err, done_irq and data_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_count | input | CW | Number of clock pulses, 0 to 8 |
| cmd_release | input | 1 | Release data pin after the last written bit |
| cmd_wait | input | 1 | Wait for device ready after the last bit |
| tmo_limit | input | TMO_W | Cycle limit for the ready wait |
| data_wr | input | 1 | Load data register strobe |
| data_in | input | DW | Byte to load |
| data_out | output | DW | Data register contents |
| busy | output | 1 | Command in progress |
| err | output | 1 | Sticky error: collision or ready timeout |
| done_irq | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| sd_in | input | 1 | Data pin input value |

## Verification
The bench targets the following corner cases:
- A zero count, which would start a clock-less busy period and send a spurious interrupt if handled wrongly.
- Counts above eight, which overrun the shift register when not clamped.
- Short reads, where a design that leaves stale upper bits or justifies to the left returns the wrong byte.
- A command issued during an active one, which would restart or change the transfer instead of only flagging an error.
- A data load during a transfer, which would corrupt the shifted bits.
- Both exits from the ready wait: a design that miscounts the timeout window or forgets the interrupt on timeout shows a wrong busy length or a missing pulse.

// File: rtl/uwire_shifter.sv
module uwire_shifter #(
  parameter int HALF_DIV = 4,
  parameter int DW       = 8,
  parameter int TMO_W    = 12,
  localparam int CW      = $clog2(DW + 1),
  localparam int DVW     = $clog2(HALF_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [CW-1:0]    cmd_count,
  input  logic             cmd_release,
  input  logic             cmd_wait,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             data_wr,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             busy,
  output logic             err,
  output logic             done_irq,
  output logic             sclk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in
);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_WAIT} st_t;

  st_t              st;
  logic [DW-1:0]    shreg;
  logic [DVW-1:0]   dcnt;
  logic [CW-1:0]    bits_left;
  logic [TMO_W-1:0] wcnt;
  logic             rd_q, rel_q, wait_q;
  logic             sclk_q, oe_q, err_q, irq_q;

  wire          tick  = (dcnt == DVW'(HALF_DIV - 1));
  wire [CW-1:0] n_cmd = (cmd_count > CW'(DW)) ? CW'(DW) : cmd_count;

  assign busy     = (st != S_IDLE);
  assign data_out = shreg;
  assign sclk     = sclk_q;
  assign sd_out   = shreg[DW-1];
  assign sd_oe    = oe_q;
  assign err      = err_q;
  assign done_irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      shreg     <= '0;
      dcnt      <= '0;
      bits_left <= '0;
      wcnt      <= '0;
      rd_q      <= 1'b0;
      rel_q     <= 1'b0;
      wait_q    <= 1'b0;
      sclk_q    <= 1'b0;
      oe_q      <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (data_wr) shreg <= data_in;
          if (cmd_valid) begin
            err_q <= 1'b0;
            if (n_cmd != '0) begin
              st        <= S_SHIFT;
              dcnt      <= '0;
              sclk_q    <= 1'b0;
              bits_left <= n_cmd;
              rd_q      <= cmd_read;
              rel_q     <= cmd_release;
              wait_q    <= cmd_wait;
              oe_q      <= !cmd_read;
              if (cmd_read) shreg <= '0;
            end
          end
        end
        S_SHIFT: begin
          if (cmd_valid) err_q <= 1'b1;
          dcnt <= tick ? '0 : dcnt + DVW'(1);
          if (tick) begin
            sclk_q <= !sclk_q;
            if (!sclk_q) begin
              if (rd_q) shreg <= {shreg[DW-2:0], sd_in};
            end else begin
              if (!rd_q) shreg <= {shreg[DW-2:0], 1'b0};
              bits_left <= bits_left - CW'(1);
              if (bits_left == CW'(1)) begin
                if (rel_q || wait_q) oe_q <= 1'b0;
                if (wait_q) begin
                  st   <= S_WAIT;
                  wcnt <= '0;
                end else begin
                  st    <= S_IDLE;
                  irq_q <= 1'b1;
                end
              end
            end
          end
        end
        S_WAIT: begin
          if (cmd_valid) err_q <= 1'b1;
          if (sd_in) begin
            st    <= S_IDLE;
            irq_q <= 1'b1;
          end else if (wcnt == tmo_limit) begin
            st    <= S_IDLE;
            irq_q <= 1'b1;
            err_q <= 1'b1;
          end else begin
            wcnt <= wcnt + TMO_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_shifter_chk.sv
module uwire_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic err,
  input logic done_irq,
  input logic sclk,
  input logic sd_out,
  input logic sd_oe
);

  a_r7_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && sd_oe) |-> $stable(sd_out));

  a_r8_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(busy));

endmodule

bind uwire_shifter uwire_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done_irq(done_irq),
  .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe)
);

// File: tb/test_uwire_shifter.sv
module test_uwire_shifter;
  localparam int HD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0, cmd_release = 1'b0, cmd_wait = 1'b0;
  logic [3:0]  cmd_count = '0;
  logic [11:0] tmo_limit = 12'd100;
  logic        data_wr = 1'b0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        busy, err, done_irq, sclk, sd_out, sd_oe;
  logic        sd_in;
  logic [7:0]  dev_q = '0;
  logic        ready_mode = 1'b0, ready_lvl = 1'b0;
  logic [7:0]  cap = '0;
  logic        rd_cur = 1'b0;
  int          bcnt = 0, icnt = 0, nclk = 0, oebad = 0, cyc = 0;
  int          checks = 0, errors = 0;

  assign sd_in = ready_mode ? ready_lvl : dev_q[7];

  always #10 clk = ~clk;

  uwire_shifter #(.HALF_DIV(HD), .DW(8), .TMO_W(12)) i_uwire_shifter (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_count(cmd_count), .cmd_release(cmd_release), .cmd_wait(cmd_wait),
    .tmo_limit(tmo_limit), .data_wr(data_wr), .data_in(data_in),
    .data_out(data_out), .busy(busy), .err(err), .done_irq(done_irq),
    .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  always @(negedge sclk) dev_q <= {dev_q[6:0], 1'b0};
  always @(posedge sclk) begin
    cap  <= {cap[6:0], sd_out};
    nclk <= nclk + 1;
  end

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (done_irq) icnt++;
    if (busy && sd_oe !== !rd_cur) oebad++;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    data_in = d; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic issue(input logic rd, input logic [3:0] cnt, input logic rel, input logic wt);
    @(negedge clk);
    bcnt = 0; icnt = 0; nclk = 0; oebad = 0; cap = '0;
    rd_cur = rd;
    cmd_read = rd; cmd_count = cnt; cmd_release = rel; cmd_wait = wt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_cmd(input logic [3:0] cnt);
    @(negedge clk);
    cmd_read = ~rd_cur; cmd_count = cnt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // {read, release, count, byte}
  localparam logic [13:0] VEC [9] = '{
    {1'b0, 1'b0, 4'd8,  8'hA5},
    {1'b0, 1'b1, 4'd3,  8'hC3},
    {1'b0, 1'b0, 4'd1,  8'h80},
    {1'b1, 1'b0, 4'd8,  8'h3C},
    {1'b1, 1'b0, 4'd5,  8'hB7},
    {1'b1, 1'b0, 4'd1,  8'h80},
    {1'b0, 1'b1, 4'd12, 8'h5A},
    {1'b1, 1'b0, 4'd9,  8'hE1},
    {1'b0, 1'b0, 4'd0,  8'hFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 busy", int'(busy), 0);
    chk("R12 sclk", int'(sclk), 0);
    chk("R12 sd_oe", int'(sd_oe), 0);
    chk("R12 err", int'(err), 0);
    chk("R12 irq", int'(done_irq), 0);
    chk("R12 data", int'(data_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      logic rd, rel;
      logic [3:0] cnt;
      logic [7:0] b;
      int n;
      {rd, rel, cnt, b} = VEC[v];
      n = (cnt > 8) ? 8 : int'(cnt);
      if (rd) begin
        load(8'hFF);
        dev_q = b;
      end else begin
        load(b);
      end
      issue(rd, cnt, rel, 1'b0);
      repeat (4) @(negedge clk);
      wait_idle();
      chk("R1 R2 R3 busy length", bcnt, 2 * n * HD);
      chk("R1 R2 R3 clock pulses", nclk, n);
      chk("R3 R7 irq count", icnt, (n > 0) ? 1 : 0);
      if (n > 0) chk("R4 R5 oe during", oebad, 0);
      if (rd) begin
        chk("R5 read data", int'(data_out), int'(b) >> (8 - n));
      end else if (n == 0) begin
        chk("R3 data kept", int'(data_out), int'(b));
      end else begin
        chk("R4 sent bits", int'(cap) & ((1 << n) - 1), int'(b) >> (8 - n));
        chk("R6 shifted reg", int'(data_out), (int'(b) << n) & 8'hFF);
        chk("R6 oe after", int'(sd_oe), rel ? 0 : 1);
      end
    end

    // R8: collision during a read
    load(8'h00);
    dev_q = 8'h9A;
    issue(1'b1, 4'd6, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    pulse_cmd(4'd2);
    wait_idle();
    chk("R8 busy unchanged", bcnt, 48);
    chk("R8 clocks unchanged", nclk, 6);
    chk("R8 err set", int'(err), 1);
    chk("R8 data intact", int'(data_out), 8'h26);

    // R3 / R8: count zero clears err
    issue(1'b0, 4'd0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R3 R8 err cleared", int'(err), 0);
    chk("R3 no busy", bcnt, 0);
    chk("R3 no irq", icnt, 0);

    // R11: data load ignored while busy
    load(8'hF0);
    issue(1'b0, 4'd4, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    data_in = 8'h0F; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
    wait_idle();
    chk("R11 sent bits", int'(cap) & 15, 15);
    chk("R11 reg after", int'(data_out), 0);

    // R9: wait for ready, device answers
    ready_mode = 1'b1; ready_lvl = 1'b0;
    tmo_limit = 12'd100;
    load(8'hC0);
    issue(1'b0, 4'd2, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R9 still busy", int'(busy), 1);
    chk("R9 line released", int'(sd_oe), 0);
    ready_lvl = 1'b1;
    @(negedge clk);
    chk("R9 busy ends", int'(busy), 0);
    wait_idle();
    chk("R9 err clear", int'(err), 0);
    chk("R9 irq", icnt, 1);

    // R10: wait for ready, timeout
    ready_lvl = 1'b0;
    tmo_limit = 12'd20;
    issue(1'b1, 4'd3, 1'b0, 1'b1);
    wait_idle();
    chk("R10 busy length", bcnt, 2 * 3 * HD + 21);
    chk("R10 err set", int'(err), 1);
    chk("R10 irq", icnt, 1);
    chk("R10 read data", int'(data_out), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule